// File: doc/BRIEF.md
# Memory Card Transaction Phase Sequencer

This block sits behind a line decoder for a three-wire synchronous memory card link. The decoder reports line-level events as single-cycle strobes: the end of a reset pulse (with a flag that says whether a clock pulse happened during it), start and stop conditions, the first level of each data bit, and each completed byte. From these strobes the sequencer works out which transaction phase the card is in and puts that phase on a plain output, so the decoder can mask start and stop detection while the card drives the data line.

A start condition opens command entry. Three bytes are collected in the fixed order control, address, data. The control code then decides what follows the next stop condition. A read command gives a known count of outgoing bytes. For a main-memory read that count depends on the address. A write or compare command means internal processing, which runs until the data line is seen high. A code that is not listed gives outgoing data with no count. The choice between outgoing data and processing is made only when the first data bit after the stop arrives.

Each time an operation phase closes, a one-cycle completion pulse reports which phase closed and why. The captured command bytes and their classification stay on outputs until the next command replaces them. The byte input is a valid-only stream with no back-pressure. The sequencer takes a byte in every cycle in which `byte_valid` is high and no higher-priority event is present, so the upstream decoder never has to hold a byte.

Top module: `card_phase_seq`

## Requirements
- R1: `phase` uses the encoding 0 idle, 1 answer-to-reset, 2 command, 3 data pending, 4 outgoing, 5 processing, and is 0 after `rst_n`. A `sym_reset` strobe moves to phase 1 if `sym_reset_clk` is high, and to phase 0 otherwise. If the phase was 1, 2, 4 or 5, the strobe also gives `op_done` with `op_reason` 1 (reset).
- R2: In phase 1 exactly four bytes are accepted. The fourth byte gives `op_done` with `op_phase` 1 and `op_reason` 0 (complete), and moves to phase 0.
- R3: A `sym_start` strobe moves to phase 2 from any phase. If the phase was 1, 2, 4 or 5, it gives `op_done` with `op_reason` 2 (start) and `op_phase` set to the phase that was left.
- R4: In phase 2 the bytes are stored as control, address, data in that order on `op_ctrl`, `op_addr`, `op_data`. The third byte gives `op_done` with `op_phase` 2 and `op_reason` 0, and moves to phase 0.
- R5: Control 0x30 sets `out_len` to 256 minus the address byte, with `proc_cmd` 0 and `unknown_cmd` 0.
- R6: Controls 0x31 and 0x34 set `out_len` to 4, with `proc_cmd` 0 and `unknown_cmd` 0.
- R7: Controls 0x33, 0x38, 0x39 and 0x3C set `proc_cmd` 1, `out_len` 0 and `unknown_cmd` 0.
- R8: Any other control sets `unknown_cmd` 1, `out_len` 0 and `proc_cmd` 0. Outgoing data that follows it has no count and ends only on a reset or a start.
- R9: A `sym_stop` strobe moves phase 0 to phase 3. In every other phase it leaves the phase unchanged.
- R10: In phase 3 the first `bit_valid` resolves the phase. A completed listed read gives phase 4 with count `out_len`. A completed processing command gives phase 5. If `bit_value` is 1 at that moment, the processing operation completes at once (op_phase 5, reason 0) and the phase becomes 0. Any other case gives phase 4 with no count. The bit consumes the command, so a later stop leads to uncounted output.
- R11: In phase 4 with a count, the byte that reaches the count gives `op_done` with `op_phase` 4 and `op_reason` 0, and moves to phase 0.
- R12: In phase 5 a `bit_valid` with `bit_value` 0 keeps the phase, and bytes are ignored. A `bit_valid` with `bit_value` 1 gives `op_done` with `op_phase` 5 and `op_reason` 0, and moves to phase 0.
- R13: In a cycle with several strobes, only one event is acted on: the first present in the order reset, start, stop, bit, byte. All others in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_reset | input | 1 | End of a card reset pulse (strobe) |
| sym_reset_clk | input | 1 | A clock pulse occurred during that reset |
| sym_start | input | 1 | Start condition (strobe) |
| sym_stop | input | 1 | Stop condition (strobe) |
| bit_valid | input | 1 | Start of a data bit (strobe) |
| bit_value | input | 1 | Data line level for that bit |
| byte_valid | input | 1 | Completed byte present (stream valid, no ready) |
| byte_data | input | 8 | Completed byte value |
| phase | output | 3 | Current transaction phase |
| out_len | output | LEN_W | Outgoing byte count of the last command, 0 if none |
| proc_cmd | output | 1 | Last command was a processing command |
| unknown_cmd | output | 1 | Last command had an unlisted control code |
| op_done | output | 1 | One-cycle pulse: an operation phase closed |
| op_phase | output | 3 | Phase that closed |
| op_reason | output | 2 | 0 complete, 1 reset, 2 start |
| op_ctrl | output | 8 | Stored control byte |
| op_addr | output | 8 | Stored address byte |
| op_data | output | 8 | Stored data byte |

## Verification
Every result is registered once. A strobe sampled at a rising edge shows up in `phase` and `op_done` on that same edge. The command classification and stored bytes appear together with the `op_done` of the third command byte. The bench drives each strobe for one cycle from a falling edge and reads the outputs on the next falling edge, which is exactly one register stage later. Expected completions go into a queue before the stimulus that causes them, and a monitor compares each pulse it sees at a falling edge against the head of that queue.

// File: rtl/card_phase_pkg.sv
package card_phase_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ATR  = 3'd1,
    PH_CMD  = 3'd2,
    PH_PEND = 3'd3,
    PH_OUT  = 3'd4,
    PH_PROC = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    RSN_DONE  = 2'd0,
    RSN_RESET = 2'd1,
    RSN_START = 2'd2
  } reason_e;

  // phases that count as an operation and report their exit
  function automatic logic is_op_phase(input phase_e p);
    return (p == PH_ATR) || (p == PH_CMD) || (p == PH_OUT) || (p == PH_PROC);
  endfunction

endpackage

// File: rtl/card_cmd_collect.sv
module card_cmd_collect #(
  parameter int NBYTES = 3,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic [7:0]       ctrl,
  output logic [7:0]       addr,
  output logic [7:0]       data
);

  logic [7:0] slot [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= 8'h00;
      end else if (wr && (idx == IDX_W'(g))) begin
        slot[g] <= din;
      end
    end
  end

  assign ctrl = slot[0];
  assign addr = slot[1];
  assign data = slot[2];

endmodule

// File: rtl/card_cmd_classify.sv
module card_cmd_classify #(
  parameter int MEM_SIZE = 256,
  parameter int SEC_LEN  = 4,
  parameter int PROT_LEN = 4,
  localparam int LEN_W   = $clog2(MEM_SIZE + 1)
) (
  input  logic [7:0]       ctrl,
  input  logic [7:0]       addr,
  output logic [LEN_W-1:0] len,
  output logic             is_proc,
  output logic             is_unknown
);

  localparam logic [7:0] C_RD_MAIN = 8'h30;
  localparam logic [7:0] C_RD_SEC  = 8'h31;
  localparam logic [7:0] C_CMP_VER = 8'h33;
  localparam logic [7:0] C_RD_PROT = 8'h34;
  localparam logic [7:0] C_WR_MAIN = 8'h38;
  localparam logic [7:0] C_WR_SEC  = 8'h39;
  localparam logic [7:0] C_WR_PROT = 8'h3C;

  always_comb begin
    len        = '0;
    is_proc    = 1'b0;
    is_unknown = 1'b0;
    unique case (ctrl)
      C_RD_MAIN: len = LEN_W'(MEM_SIZE) - LEN_W'(addr);
      C_RD_SEC:  len = LEN_W'(SEC_LEN);
      C_RD_PROT: len = LEN_W'(PROT_LEN);
      C_CMP_VER, C_WR_MAIN, C_WR_SEC, C_WR_PROT: is_proc = 1'b1;
      default:   is_unknown = 1'b1;
    endcase
  end

endmodule

// File: rtl/card_phase_fsm.sv
module card_phase_fsm
  import card_phase_pkg::*;
#(
  parameter int ATR_BYTES = 4,
  parameter int CMD_BYTES = 3,
  parameter int LEN_W     = 9,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_reset,
  input  logic             ev_reset_clk,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             ev_bit,
  input  logic             bit_val,
  input  logic             byte_v,
  input  logic [LEN_W-1:0] cls_len,
  input  logic             cls_proc,
  input  logic             cls_unknown,
  output logic             cmd_wr,
  output logic [IDX_W-1:0] cmd_idx,
  output phase_e           phase,
  output logic [LEN_W-1:0] out_len,
  output logic             proc_cmd,
  output logic             unknown_cmd,
  output logic             op_done,
  output phase_e           op_phase,
  output reason_e          op_reason
);

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic [LEN_W-1:0] len_q;
  logic             armed_q;
  logic             bounded_q;
  logic             proc_q;
  logic             unk_q;
  logic             take_byte;

  assign cnt_nxt   = cnt_q + 1'b1;
  assign take_byte = byte_v && !ev_reset && !ev_start && !ev_stop && !ev_bit;
  assign cmd_wr    = take_byte && (phase_q == PH_CMD);
  assign cmd_idx   = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      armed_q   <= 1'b0;
      bounded_q <= 1'b0;
      proc_q    <= 1'b0;
      unk_q     <= 1'b0;
      op_done   <= 1'b0;
      op_phase  <= PH_IDLE;
      op_reason <= RSN_DONE;
    end else begin
      op_done <= 1'b0;
      if (ev_reset) begin
        if (is_op_phase(phase_q)) begin
          op_done   <= 1'b1;
          op_phase  <= phase_q;
          op_reason <= RSN_RESET;
        end
        phase_q <= ev_reset_clk ? PH_ATR : PH_IDLE;
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (ev_start) begin
        if (is_op_phase(phase_q)) begin
          op_done   <= 1'b1;
          op_phase  <= phase_q;
          op_reason <= RSN_START;
        end
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (ev_stop) begin
        if (phase_q == PH_IDLE) phase_q <= PH_PEND;
      end else if (ev_bit) begin
        if (phase_q == PH_PEND) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          if (armed_q && proc_q) begin
            if (bit_val) begin
              op_done   <= 1'b1;
              op_phase  <= PH_PROC;
              op_reason <= RSN_DONE;
              phase_q   <= PH_IDLE;
            end else begin
              phase_q <= PH_PROC;
            end
          end else begin
            phase_q   <= PH_OUT;
            bounded_q <= armed_q && !unk_q;
          end
        end else if (phase_q == PH_PROC && bit_val) begin
          op_done   <= 1'b1;
          op_phase  <= PH_PROC;
          op_reason <= RSN_DONE;
          phase_q   <= PH_IDLE;
        end
      end else if (byte_v) begin
        unique case (phase_q)
          PH_ATR: begin
            if (cnt_nxt == LEN_W'(ATR_BYTES)) begin
              op_done   <= 1'b1;
              op_phase  <= PH_ATR;
              op_reason <= RSN_DONE;
              phase_q   <= PH_IDLE;
            end
            cnt_q <= cnt_nxt;
          end
          PH_CMD: begin
            if (cnt_nxt == LEN_W'(CMD_BYTES)) begin
              op_done   <= 1'b1;
              op_phase  <= PH_CMD;
              op_reason <= RSN_DONE;
              phase_q   <= PH_IDLE;
              len_q     <= cls_len;
              proc_q    <= cls_proc;
              unk_q     <= cls_unknown;
              armed_q   <= 1'b1;
            end
            cnt_q <= cnt_nxt;
          end
          PH_OUT: begin
            if (bounded_q && (cnt_nxt == len_q)) begin
              op_done   <= 1'b1;
              op_phase  <= PH_OUT;
              op_reason <= RSN_DONE;
              phase_q   <= PH_IDLE;
            end
            cnt_q <= cnt_nxt;
          end
          default: ;
        endcase
      end
    end
  end

  assign phase       = phase_q;
  assign out_len     = len_q;
  assign proc_cmd    = proc_q;
  assign unknown_cmd = unk_q;

endmodule

// File: rtl/card_phase_seq.sv
module card_phase_seq
  import card_phase_pkg::*;
#(
  parameter int  MEM_SIZE  = 256,
  parameter int  ATR_BYTES = 4,
  parameter int  SEC_LEN   = 4,
  parameter int  PROT_LEN  = 4,
  localparam int LEN_W     = $clog2(MEM_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_reset,
  input  logic             sym_reset_clk,
  input  logic             sym_start,
  input  logic             sym_stop,
  input  logic             bit_valid,
  input  logic             bit_value,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic [2:0]       phase,
  output logic [LEN_W-1:0] out_len,
  output logic             proc_cmd,
  output logic             unknown_cmd,
  output logic             op_done,
  output logic [2:0]       op_phase,
  output logic [1:0]       op_reason,
  output logic [7:0]       op_ctrl,
  output logic [7:0]       op_addr,
  output logic [7:0]       op_data
);

  localparam int CMD_BYTES = 3;
  localparam int IDX_W     = $clog2(CMD_BYTES);

  logic             cmd_wr;
  logic [IDX_W-1:0] cmd_idx;
  logic [LEN_W-1:0] cls_len;
  logic             cls_proc;
  logic             cls_unknown;
  phase_e           phase_w;
  phase_e           op_phase_w;
  reason_e          op_reason_w;

  card_cmd_collect #(.NBYTES(CMD_BYTES)) u_collect (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cmd_wr),
    .idx  (cmd_idx),
    .din  (byte_data),
    .ctrl (op_ctrl),
    .addr (op_addr),
    .data (op_data)
  );

  card_cmd_classify #(
    .MEM_SIZE(MEM_SIZE), .SEC_LEN(SEC_LEN), .PROT_LEN(PROT_LEN)
  ) u_classify (
    .ctrl      (op_ctrl),
    .addr      (op_addr),
    .len       (cls_len),
    .is_proc   (cls_proc),
    .is_unknown(cls_unknown)
  );

  card_phase_fsm #(
    .ATR_BYTES(ATR_BYTES), .CMD_BYTES(CMD_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_reset    (sym_reset),
    .ev_reset_clk(sym_reset_clk),
    .ev_start    (sym_start),
    .ev_stop     (sym_stop),
    .ev_bit      (bit_valid),
    .bit_val     (bit_value),
    .byte_v      (byte_valid),
    .cls_len     (cls_len),
    .cls_proc    (cls_proc),
    .cls_unknown (cls_unknown),
    .cmd_wr      (cmd_wr),
    .cmd_idx     (cmd_idx),
    .phase       (phase_w),
    .out_len     (out_len),
    .proc_cmd    (proc_cmd),
    .unknown_cmd (unknown_cmd),
    .op_done     (op_done),
    .op_phase    (op_phase_w),
    .op_reason   (op_reason_w)
  );

  assign phase     = phase_w;
  assign op_phase  = op_phase_w;
  assign op_reason = op_reason_w;

endmodule

// File: rtl/card_phase_seq_chk.sv
module card_phase_seq_chk #(
  parameter int  MEM_SIZE = 256,
  localparam int LEN_W    = $clog2(MEM_SIZE + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_reset,
  input logic             sym_reset_clk,
  input logic             sym_start,
  input logic             sym_stop,
  input logic             bit_valid,
  input logic             bit_value,
  input logic [2:0]       phase,
  input logic [LEN_W-1:0] out_len,
  input logic             op_done,
  input logic [2:0]       op_phase,
  input logic [1:0]       op_reason
);

  logic in_op;
  assign in_op = (phase == 3'd1) || (phase == 3'd2) || (phase == 3'd4) || (phase == 3'd5);

  a_r1_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd5);

  a_r1_clocked_reset_atr: assert property (@(posedge clk) disable iff (!rst_n)
    sym_reset && sym_reset_clk |=> phase == 3'd1);

  a_r1_reset_closes_op: assert property (@(posedge clk) disable iff (!rst_n)
    sym_reset && in_op |=> op_done && op_reason == 2'd1 && op_phase == $past(phase));

  a_r3_start_enters_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_reset && sym_start |=> phase == 3'd2);

  a_r9_stop_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_reset && !sym_start && sym_stop && phase != 3'd0 |=> $stable(phase));

  a_r11_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_len <= LEN_W'(MEM_SIZE));

  a_r12_proc_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_reset && !sym_start && !sym_stop && bit_valid && !bit_value && phase == 3'd5
    |=> phase == 3'd5);

  a_r13_exit_target: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> phase == 3'd0 || phase == 3'd1 || phase == 3'd2);

endmodule

bind card_phase_seq card_phase_seq_chk #(.MEM_SIZE(MEM_SIZE)) u_chk (.*);

// File: tb/tb_card_phase_seq.sv
module tb_card_phase_seq;

  localparam int LEN_W = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_reset = 1'b0, sym_reset_clk = 1'b0, sym_start = 1'b0, sym_stop = 1'b0;
  logic bit_valid = 1'b0, bit_value = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [2:0] phase;
  logic [LEN_W-1:0] out_len;
  logic proc_cmd, unknown_cmd, op_done;
  logic [2:0] op_phase;
  logic [1:0] op_reason;
  logic [7:0] op_ctrl, op_addr, op_data;

  always #5 clk = ~clk;

  card_phase_seq dut (.*);

  typedef struct packed { logic [2:0] ph; logic [1:0] rs; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_op(input int ph, input int rs);
    exp_t e;
    e.ph = 3'(ph);
    e.rs = 2'(rs);
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && op_done) begin
      if (exp_q.size() == 0) begin
        chk("op_done unexpected (R1..R12)", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("op_phase (R1..R12)", int'(op_phase), int'(e.ph));
        chk("op_reason (R1..R12)", int'(op_reason), int'(e.rs));
      end
    end
  end

  task automatic step(input logic r_, rc_, st_, sp_, bt_, bv_, yv_, input logic [7:0] yd_);
    sym_reset = r_; sym_reset_clk = rc_; sym_start = st_; sym_stop = sp_;
    bit_valid = bt_; bit_value = bv_; byte_valid = yv_; byte_data = yd_;
    @(negedge clk);
    sym_reset = 0; sym_reset_clk = 0; sym_start = 0; sym_stop = 0;
    bit_valid = 0; bit_value = 0; byte_valid = 0; byte_data = 8'h00;
  endtask

  task automatic do_reset(input logic withclk); step(1, withclk, 0, 0, 0, 0, 0, 8'h00); endtask
  task automatic do_start();                   step(0, 0, 1, 0, 0, 0, 0, 8'h00); endtask
  task automatic do_stop();                    step(0, 0, 0, 1, 0, 0, 0, 8'h00); endtask
  task automatic do_bit(input logic v);        step(0, 0, 0, 0, 1, v, 0, 8'h00); endtask
  task automatic do_byte(input logic [7:0] b); step(0, 0, 0, 0, 0, 0, 1, b);     endtask

  function automatic int exp_len(input logic [7:0] c, input logic [7:0] a);
    if (c == 8'h30) return 256 - int'(a);
    if (c == 8'h31 || c == 8'h34) return 4;
    return 0;
  endfunction

  // command from idle: three bytes, then check fields and classification
  task automatic send_cmd(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
    logic pr;
    pr = (c == 8'h33 || c == 8'h38 || c == 8'h39 || c == 8'h3C);
    do_start();
    chk("R3 phase after start", int'(phase), 2);
    do_byte(c);
    do_byte(a);
    expect_op(2, 0);
    do_byte(d);
    chk("R4 phase after third byte", int'(phase), 0);
    chk("R4 op_ctrl", int'(op_ctrl), int'(c));
    chk("R4 op_addr", int'(op_addr), int'(a));
    chk("R4 op_data", int'(op_data), int'(d));
    chk("R5/R6 out_len", int'(out_len), exp_len(c, a));
    chk("R7 proc_cmd", int'(proc_cmd), int'(pr));
    chk("R8 unknown_cmd", int'(unknown_cmd), int'(!pr && exp_len(c, a) == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset op_done", int'(op_done), 0);

    // R1: plain reset goes idle, clocked reset goes to answer-to-reset
    do_reset(0);
    chk("R1 plain reset idle", int'(phase), 0);
    do_reset(1);
    chk("R1 clocked reset atr", int'(phase), 1);

    // R2 and R9: answer-to-reset runs exactly four bytes, stop ignored
    do_byte(8'hA2); do_byte(8'h13); do_byte(8'h10);
    chk("R2 still atr after 3 bytes", int'(phase), 1);
    do_stop();
    chk("R9 stop ignored in atr", int'(phase), 1);
    expect_op(1, 0);
    do_byte(8'h91);
    chk("R2 idle after 4 bytes", int'(phase), 0);

    // R5, R10, R11: main read with address 0x10, 240 bytes
    send_cmd(8'h30, 8'h10, 8'hAA);
    do_stop();
    chk("R9 stop from idle pending", int'(phase), 3);
    do_bit(0);
    chk("R10 resolve to out", int'(phase), 4);
    for (int i = 0; i < 239; i++) do_byte(8'(i));
    chk("R11 out before count", int'(phase), 4);
    expect_op(4, 0);
    do_byte(8'hEF);
    chk("R11 idle at count", int'(phase), 0);

    // R6: security read, 4 bytes
    send_cmd(8'h31, 8'h00, 8'h00);
    do_stop(); do_bit(1);
    chk("R10 resolve read to out", int'(phase), 4);
    do_byte(1); do_byte(2); do_byte(3);
    expect_op(4, 0);
    do_byte(4);
    chk("R11 security read done", int'(phase), 0);

    // R6 and R3: protection read cut short by a start, then R1 reset of a partial command
    send_cmd(8'h34, 8'h05, 8'h00);
    do_stop(); do_bit(0); do_byte(8'h55); do_byte(8'h66);
    expect_op(4, 2);
    do_start();
    chk("R3 start ends out", int'(phase), 2);
    do_byte(8'h11);
    expect_op(2, 1);
    do_reset(0);
    chk("R1 reset ends command", int'(phase), 0);

    // R7 and R12: processing with low bits, bytes ignored, ends on high bit
    send_cmd(8'h33, 8'h01, 8'h02);
    do_stop(); do_bit(0);
    chk("R10 resolve to proc", int'(phase), 5);
    do_bit(0);
    chk("R12 proc holds on low bit", int'(phase), 5);
    do_byte(8'hFF);
    chk("R12 byte ignored in proc", int'(phase), 5);
    expect_op(5, 0);
    do_bit(1);
    chk("R12 proc ends on high bit", int'(phase), 0);

    // R10: processing that is already finished at the first bit
    send_cmd(8'h3C, 8'h02, 8'h03);
    do_stop();
    expect_op(5, 0);
    do_bit(1);
    chk("R10 immediate proc end", int'(phase), 0);
    send_cmd(8'h38, 8'h04, 8'h05);
    send_cmd(8'h39, 8'h06, 8'h07);

    // R5 boundary: address 0 gives the full size
    send_cmd(8'h30, 8'h00, 8'h00);

    // R8: unknown code, uncounted output ended by clocked reset
    send_cmd(8'h55, 8'h01, 8'h02);
    do_stop(); do_bit(0);
    chk("R8 unknown resolves to out", int'(phase), 4);
    for (int i = 0; i < 300; i++) do_byte(8'hC3);
    chk("R8 unknown out unbounded", int'(phase), 4);
    expect_op(4, 1);
    do_reset(1);
    chk("R1 reset ends out into atr", int'(phase), 1);

    // R13: start and byte together, byte dropped
    expect_op(1, 2);
    step(0, 0, 1, 0, 0, 0, 1, 8'h99);
    chk("R13 start wins over byte", int'(phase), 2);
    do_byte(8'h31); do_byte(8'h07);
    expect_op(2, 0);
    do_byte(8'h08);
    chk("R13 dropped byte not stored", int'(op_ctrl), 8'h31);

    // R13: reset and start together from idle, reset wins
    step(1, 1, 1, 0, 0, 0, 0, 8'h00);
    chk("R13 reset wins over start", int'(phase), 1);
    do_byte(1); do_byte(2); do_byte(3);
    expect_op(1, 0);
    do_byte(4);

    // R10: command consumed, a later stop gives uncounted output
    do_stop(); do_bit(0);
    chk("R10 consumed command out", int'(phase), 4);
    for (int i = 0; i < 8; i++) do_byte(8'h00);
    chk("R10 consumed command unbounded", int'(phase), 4);
    expect_op(4, 1);
    do_reset(0);
    chk("R1 reset to idle", int'(phase), 0);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule